// File: doc/BRIEF.md
# Programming Page Buffer Controller

This block sits on the target side of a serial programming path, between the instruction decoder and the nonvolatile arrays. The decoder hands it one command per cycle: an opcode, an address and a data byte. Program-memory words are gathered byte by byte into a word-organised page buffer. A page-write command then sends the whole buffer out to the program array as a burst of word writes. Data-memory bytes are gathered into a small page buffer, and a page commit writes back only the bytes that were loaded. The block also takes single-byte data-memory writes, which replace the old byte outright.

Every commit raises `busy` for a fixed, parameterised number of cycles. All commands that arrive while `busy` is high are dropped. The data-memory array is modelled inside the block and has a combinational read port. The program array is outside the block and receives the commit burst on the `flashWr*` outputs.

Top module: `prog_page_buf`

## Requirements
- R1: Reset state. After reset, `busy` and `orderErr` are 0, `flashWrEn` is 0, and every data-memory location reads 0xFF on `eeRdData`. Every program-buffer word holds 0xFFFF, so a page write issued straight after reset emits only 0xFFFF words.
- R2: Opcode 1 (low-byte load) writes `cmdData` into bits 7:0 of the buffer word selected by `cmdAddr[5:0]`. It also arms that word for a high-byte load.
- R3: Opcode 2 (high-byte load) writes `cmdData` into bits 15:8 of the word selected by `cmdAddr[5:0]` and disarms that word. If the word was not armed by a low-byte load since its last high-byte load or page write, `orderErr` goes to 1 and stays at 1 until reset. Bits 7:0 of the word are never altered by opcode 2.
- R4: Opcode 3 (program page write) uses `cmdAddr[12:6]` as the page number. Starting in the cycle after the command is accepted, it emits 64 consecutive cycles of `flashWrEn`=1. Cycle k (k = 0 to 63) carries `flashWrAddr` = {page, k} and `flashWrData` = buffer word k. Each emitted word is reset to 0xFFFF and disarmed.
- R5: Opcode 4 (data page load) stores `cmdData` in byte `cmdAddr[1:0]` of the data page buffer and marks that byte loaded. Opcode 5 (data page commit) writes only the loaded bytes to data-memory address {`cmdAddr[5:2]`, byte}. Every other location keeps its value, and the loaded mask is cleared, so a second commit with no loads changes nothing.
- R6: Opcode 6 (single-byte write) makes location `cmdAddr[5:0]` equal to `cmdData`, whatever its previous contents. The location is erased and then written; the new value is not combined with the old one.
- R7: A command is accepted only while `busy` is 0. Opcodes 3, 5 and 6 set `busy` high for exactly BUSY_CYCLES cycles (default 80), starting in the cycle after acceptance. Commands presented while `busy` is 1, and opcodes 0 and 7, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode (1 lo load, 2 hi load, 3 page write, 4 data load, 5 data commit, 6 byte write) |
| cmdAddr | input | 13 | Command address |
| cmdData | input | 8 | Command data byte |
| eeRdAddr | input | 6 | Data-memory read address |
| busy | output | 1 | Commit in progress; commands ignored |
| orderErr | output | 1 | Sticky high-before-low load error |
| flashWrEn | output | 1 | Program array word write strobe |
| flashWrAddr | output | 13 | Program array word address |
| flashWrData | output | 16 | Program array word data |
| eeRdData | output | 8 | Data-memory read data |

## Verification
The bench checks that a high-byte load on an unarmed word raises `orderErr` while the low byte survives into the commit burst. A design that clobbered the low byte, or cleared the flag, would show a wrong burst word or a dropped flag. It commits a data page with only some bytes loaded, and then commits again with nothing loaded. A design that wrote stale buffer bytes, or kept the mask, would corrupt neighbouring locations. It writes 0x0F and then 0xF0 to one location, which catches a design that ANDs the new byte into the old one instead of erasing first. It also injects a load in the middle of every busy window and checks the exact busy length, catching a design that accepts commands early or times the window wrongly.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_FLO     = 3'd1,
    OP_FHI     = 3'd2,
    OP_FPAGE   = 3'd3,
    OP_ELOAD   = 3'd4,
    OP_ECOMMIT = 3'd5,
    OP_EBYTE   = 3'd6,
    OP_RSVD    = 3'd7
  } pgb_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fLoadLo;
    logic fLoadHi;
    logic fWipe;
    logic eLoad;
    logic eCommit;
    logic eByteWr;
  } pgb_stb_t;

endpackage

// File: rtl/pgb_ctrl.sv
module pgb_ctrl
  import pgb_pkg::*;
#(
  parameter int WORD_BITS   = 6,
  parameter int PAGE_BITS   = 7,
  parameter int BUSY_CYCLES = 80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [PAGE_BITS-1:0] cmdPage,
  output logic                 busy,
  output pgb_stb_t             stb,
  output logic                 streamOn,
  output logic [WORD_BITS-1:0] streamIdx,
  output logic [PAGE_BITS-1:0] streamPage
);

  localparam int WORDS = 1 << WORD_BITS;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  initial begin
    assert (BUSY_CYCLES >= WORDS)
      else $error("BUSY_CYCLES must cover the commit burst");
  end

  pgb_op_e    op;
  logic       accept;
  logic       isCommit;
  logic       startBurst;
  logic [CNT_W-1:0] busyCnt;

  assign op     = pgb_op_e'(cmdOp);
  assign accept = cmdValid && !busy;
  assign busy   = (busyCnt != '0);

  always_comb begin
    stb        = '0;
    isCommit   = 1'b0;
    startBurst = 1'b0;
    if (accept) begin
      case (op)
        OP_FLO:     stb.fLoadLo = 1'b1;
        OP_FHI:     stb.fLoadHi = 1'b1;
        OP_FPAGE: begin
          isCommit   = 1'b1;
          startBurst = 1'b1;
        end
        OP_ELOAD:   stb.eLoad = 1'b1;
        OP_ECOMMIT: begin
          stb.eCommit = 1'b1;
          isCommit    = 1'b1;
        end
        OP_EBYTE: begin
          stb.eByteWr = 1'b1;
          isCommit    = 1'b1;
        end
        default: ;
      endcase
    end
    stb.fWipe = streamOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (isCommit) begin
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      streamOn   <= 1'b0;
      streamIdx  <= '0;
      streamPage <= '0;
    end else if (startBurst) begin
      streamOn   <= 1'b1;
      streamIdx  <= '0;
      streamPage <= cmdPage;
    end else if (streamOn) begin
      streamIdx <= streamIdx + 1'b1;
      if (streamIdx == WORD_BITS'(WORDS - 1)) streamOn <= 1'b0;
    end
  end

  AST_BURST_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    streamOn |-> busy);  // R4

  AST_BUSY_END_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !streamOn);  // R7

  AST_BURST_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (streamOn && $past(streamOn)) |-> (streamIdx == $past(streamIdx) + 1'b1));  // R4

endmodule

// File: rtl/pgb_datapath.sv
module pgb_datapath
  import pgb_pkg::*;
#(
  parameter int WORD_BITS    = 6,
  parameter int EE_BYTE_BITS = 2,
  parameter int EE_PAGE_BITS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pgb_stb_t                stb,
  input  logic [WORD_BITS-1:0]    wordSel,
  input  logic [EE_BYTE_BITS+EE_PAGE_BITS-1:0] eeAddr,
  input  logic [7:0]              cmdData,
  input  logic [WORD_BITS-1:0]    streamIdx,
  input  logic [EE_BYTE_BITS+EE_PAGE_BITS-1:0] eeRdAddr,
  output logic [15:0]             burstData,
  output logic [7:0]              eeRdData,
  output logic                    orderErr
);

  localparam int WORDS        = 1 << WORD_BITS;
  localparam int EBYTES       = 1 << EE_BYTE_BITS;
  localparam int EE_ADDR_BITS = EE_BYTE_BITS + EE_PAGE_BITS;
  localparam int EE_DEPTH     = 1 << EE_ADDR_BITS;

  logic [15:0]       flashBuf [WORDS];
  logic [WORDS-1:0]  lowSeen;
  logic [7:0]        eeBuf    [EBYTES];
  logic [EBYTES-1:0] eeValid;
  logic [7:0]        eeArr    [EE_DEPTH];

  logic [EE_BYTE_BITS-1:0] eeByte;
  logic [EE_PAGE_BITS-1:0] eePage;

  assign eeByte    = eeAddr[EE_BYTE_BITS-1:0];
  assign eePage    = eeAddr[EE_ADDR_BITS-1:EE_BYTE_BITS];
  assign burstData = flashBuf[streamIdx];
  assign eeRdData  = eeArr[eeRdAddr];

  // program-memory word buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) flashBuf[w] <= 16'hFFFF;
      lowSeen  <= '0;
      orderErr <= 1'b0;
    end else begin
      if (stb.fWipe) begin
        flashBuf[streamIdx] <= 16'hFFFF;
        lowSeen[streamIdx]  <= 1'b0;
      end
      if (stb.fLoadLo) begin
        flashBuf[wordSel][7:0] <= cmdData;
        lowSeen[wordSel]       <= 1'b1;
      end
      if (stb.fLoadHi) begin
        flashBuf[wordSel][15:8] <= cmdData;
        lowSeen[wordSel]        <= 1'b0;
        if (!lowSeen[wordSel]) orderErr <= 1'b1;
      end
    end
  end

  // data-memory page buffer and loaded mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < EBYTES; b++) eeBuf[b] <= 8'hFF;
      eeValid <= '0;
    end else if (stb.eCommit) begin
      eeValid <= '0;
    end else if (stb.eLoad) begin
      eeBuf[eeByte]   <= cmdData;
      eeValid[eeByte] <= 1'b1;
    end
  end

  // behavioural data-memory array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < EE_DEPTH; a++) eeArr[a] <= 8'hFF;
    end else if (stb.eCommit) begin
      for (int b = 0; b < EBYTES; b++) begin
        if (eeValid[b]) eeArr[{eePage, EE_BYTE_BITS'(b)}] <= eeBuf[b];
      end
    end else if (stb.eByteWr) begin
      eeArr[eeAddr] <= cmdData;
    end
  end

  AST_ORDER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    orderErr |=> orderErr);  // R3

  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    stb.fLoadHi |=> (flashBuf[$past(wordSel)][7:0] == $past(flashBuf[wordSel][7:0])));  // R3

  AST_WIPE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    stb.fWipe |=> (flashBuf[$past(streamIdx)] == 16'hFFFF));  // R4

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.eCommit |=> (eeValid == '0));  // R5

  AST_BYTE_REPLACE: assert property (@(posedge clk) disable iff (!rstN)
    stb.eByteWr |=> (eeArr[$past(eeAddr)] == $past(cmdData)));  // R6

endmodule

// File: rtl/prog_page_buf.sv
module prog_page_buf
  import pgb_pkg::*;
#(
  parameter int WORD_BITS    = 6,
  parameter int PAGE_BITS    = 7,
  parameter int EE_BYTE_BITS = 2,
  parameter int EE_PAGE_BITS = 4,
  parameter int BUSY_CYCLES  = 80,
  localparam int ADDR_BITS    = PAGE_BITS + WORD_BITS,
  localparam int EE_ADDR_BITS = EE_BYTE_BITS + EE_PAGE_BITS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [2:0]              cmdOp,
  input  logic [ADDR_BITS-1:0]    cmdAddr,
  input  logic [7:0]              cmdData,
  input  logic [EE_ADDR_BITS-1:0] eeRdAddr,
  output logic                    busy,
  output logic                    orderErr,
  output logic                    flashWrEn,
  output logic [ADDR_BITS-1:0]    flashWrAddr,
  output logic [15:0]             flashWrData,
  output logic [7:0]              eeRdData
);

  pgb_stb_t             stb;
  logic                 streamOn;
  logic [WORD_BITS-1:0] streamIdx;
  logic [PAGE_BITS-1:0] streamPage;

  pgb_ctrl #(
    .WORD_BITS  (WORD_BITS),
    .PAGE_BITS  (PAGE_BITS),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdPage   (cmdAddr[ADDR_BITS-1:WORD_BITS]),
    .busy      (busy),
    .stb       (stb),
    .streamOn  (streamOn),
    .streamIdx (streamIdx),
    .streamPage(streamPage)
  );

  pgb_datapath #(
    .WORD_BITS   (WORD_BITS),
    .EE_BYTE_BITS(EE_BYTE_BITS),
    .EE_PAGE_BITS(EE_PAGE_BITS)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wordSel  (cmdAddr[WORD_BITS-1:0]),
    .eeAddr   (cmdAddr[EE_ADDR_BITS-1:0]),
    .cmdData  (cmdData),
    .streamIdx(streamIdx),
    .eeRdAddr (eeRdAddr),
    .burstData(flashWrData),
    .eeRdData (eeRdData),
    .orderErr (orderErr)
  );

  assign flashWrEn   = streamOn;
  assign flashWrAddr = {streamPage, streamIdx};

endmodule

// File: tb/tb_prog_page_buf.sv
`timescale 1ns/1ps
module tb_prog_page_buf;

  localparam int BUSY = 80;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [12:0] cmdAddr = '0;
  logic [7:0]  cmdData = '0;
  logic [5:0]  eeRdAddr = '0;
  logic        busy, orderErr, flashWrEn;
  logic [12:0] flashWrAddr;
  logic [15:0] flashWrData;
  logic [7:0]  eeRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] expFlash [64];
  bit          expLow   [64];
  logic [7:0]  expEeBuf [4];
  bit          expValid [4];
  logic [7:0]  expEe    [64];
  bit          expErr;

  always #2 clk = ~clk;

  prog_page_buf #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .eeRdAddr(eeRdAddr),
    .busy(busy), .orderErr(orderErr), .flashWrEn(flashWrEn),
    .flashWrAddr(flashWrAddr), .flashWrData(flashWrData), .eeRdData(eeRdData)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt_of(bit b);
    return b ? 32'd1 : 32'd0;
  endfunction

  // model update for an accepted command
  task automatic model(logic [2:0] op, logic [12:0] a, logic [7:0] d);
    case (op)
      3'd1: begin expFlash[a[5:0]][7:0] = d; expLow[a[5:0]] = 1; end
      3'd2: begin
        if (!expLow[a[5:0]]) expErr = 1;
        expFlash[a[5:0]][15:8] = d;
        expLow[a[5:0]] = 0;
      end
      3'd4: begin expEeBuf[a[1:0]] = d; expValid[a[1:0]] = 1; end
      3'd5: for (int b = 0; b < 4; b++) begin
        if (expValid[b]) expEe[{a[5:2], 2'(b)}] = expEeBuf[b];
        expValid[b] = 0;
      end
      3'd6: expEe[a[5:0]] = d;
      default: ;
    endcase
  endtask

  // wait out a commit window: checks busy length, burst, ignored load (R7, R4)
  task automatic wait_commit(bit isFlash, logic [6:0] page);
    for (int k = 1; k <= BUSY; k++) begin
      chk(busy === 1'b1, "R7 busy high in window", cnt_of(busy), 1);
      if (isFlash && k <= 64) begin
        chk(flashWrEn === 1'b1, "R4 burst strobe", cnt_of(flashWrEn), 1);
        chk(flashWrAddr === {page, 6'(k - 1)}, "R4 burst address", flashWrAddr, {page, 6'(k - 1)});
        chk(flashWrData === expFlash[k - 1], "R4 burst word", flashWrData, expFlash[k - 1]);
      end else begin
        chk(flashWrEn === 1'b0, "R4 no strobe outside burst", cnt_of(flashWrEn), 0);
      end
      if (k == 3) begin
        cmdValid = 1'b1;
        cmdOp    = ($urandom % 2) ? 3'd1 : 3'd4;
        cmdAddr  = 13'($urandom);
        cmdData  = 8'($urandom);
      end
      if (k == 4) cmdValid = 1'b0;
      @(negedge clk);
    end
    chk(busy === 1'b0, "R7 busy drops after BUSY_CYCLES", cnt_of(busy), 0);
    if (isFlash) for (int w = 0; w < 64; w++) begin
      expFlash[w] = 16'hFFFF;
      expLow[w] = 0;
    end
  endtask

  // issue at a negedge while idle; returns at the next negedge
  task automatic issue(logic [2:0] op, logic [12:0] a, logic [7:0] d);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    model(op, a, d);
    @(negedge clk);
    cmdValid = 1'b0;
    chk(orderErr === expErr, "R3 order error flag", cnt_of(orderErr), cnt_of(expErr));
    if (op == 3'd3) wait_commit(1'b1, a[12:6]);
    else if (op == 3'd5 || op == 3'd6) wait_commit(1'b0, 7'd0);
    else chk(busy === 1'b0, "R7 no busy for load", cnt_of(busy), 0);
  endtask

  task automatic check_ee(string req);
    for (int a = 0; a < 64; a++) begin
      eeRdAddr = 6'(a);
      #0.5;
      chk(eeRdData === expEe[a], req, eeRdData, expEe[a]);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int w = 0; w < 64; w++) begin expFlash[w] = 16'hFFFF; expLow[w] = 0; expEe[w] = 8'hFF; end
    for (int b = 0; b < 4; b++) begin expEeBuf[b] = 8'hFF; expValid[b] = 0; end
    expErr = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0, "R1 busy after reset", cnt_of(busy), 0);
    chk(orderErr === 1'b0, "R1 orderErr after reset", cnt_of(orderErr), 0);
    chk(flashWrEn === 1'b0, "R1 no burst after reset", cnt_of(flashWrEn), 0);
    check_ee("R1 data memory erased after reset");
    issue(3'd3, {7'h55, 6'd0}, 8'h00);   // R1 buffer blank, R4 burst

    // R2 / R3 ordered loads
    issue(3'd1, 13'd5, 8'hA1);
    issue(3'd2, 13'd5, 8'hB2);
    issue(3'd1, 13'd63, 8'h3C);
    issue(3'd2, 13'd63, 8'hC3);
    issue(3'd1, 13'd0, 8'h11);
    issue(0, 13'd9, 8'h77);              // R7 idle opcode no effect
    issue(7, 13'd9, 8'h77);
    chk(orderErr === 1'b0, "R3 no error on ordered loads", cnt_of(orderErr), 0);
    issue(3'd3, {7'h12, 6'd0}, 8'h00);   // R2 R4

    // R3 high without low: low kept, sticky flag
    issue(3'd1, 13'd7, 8'h5A);
    issue(3'd2, 13'd7, 8'h01);
    issue(3'd2, 13'd7, 8'h02);           // disarmed -> error
    chk(orderErr === 1'b1, "R3 flag set on unarmed high", cnt_of(orderErr), 1);
    issue(3'd2, 13'd20, 8'hEE);
    issue(3'd3, {7'h7F, 6'd0}, 8'h00);
    chk(orderErr === 1'b1, "R3 flag sticky after commit", cnt_of(orderErr), 1);

    // R5 partial page commit and mask clear
    issue(3'd4, 13'd0, 8'h10);
    issue(3'd4, 13'd2, 8'h32);
    issue(3'd5, {7'd0, 4'd3, 2'd1}, 8'h00);
    check_ee("R5 only loaded bytes change");
    issue(3'd5, {7'd0, 4'd5, 2'd0}, 8'h00);
    check_ee("R5 mask cleared, empty commit inert");

    // R6 erase then write
    issue(3'd6, 13'd17, 8'h0F);
    issue(3'd6, 13'd17, 8'hF0);
    check_ee("R6 byte replaced exactly");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom % 100);
      if (r < 30) op = 3'd1;
      else if (r < 50) op = 3'd2;
      else if (r < 80) op = 3'd4;
      else if (r < 86) op = 3'd3;
      else if (r < 93) op = 3'd5;
      else op = 3'd6;
      issue(op, 13'($urandom), 8'($urandom));
      if (op == 3'd5 || op == 3'd6) check_ee("R5 R6 random data memory");
    end
    issue(3'd3, 13'h1FC0, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule